// File: doc/BRIEF.md
# Programmable CRC Engine with Input FIFO

The block computes a cyclic redundancy check over a stream of data words using a polynomial that software programs. It has a small write-only word bus. Through this bus, software sets the tap pattern, the register length, the data word width and the order in which input bits enter. It also pushes words into an eight-entry FIFO, starts the calculation, and reads or seeds the accumulated result.

Once the run flag is set, the engine takes one word at a time from the FIFO and shifts it into the CRC register two bits per clock. An odd word width ends with a single-bit step. When the FIFO is empty and the last bit has gone through, the engine clears the run flag by itself. A one-cycle interrupt pulse marks one of two events, chosen by software: the FIFO draining its last word, or the engine finishing the run.

The result register is kept between runs. Software can clear it by writing zero, or leave it alone so that a new batch of words continues the earlier checksum.

Top module: `crc_prog_engine`

## Requirements
- R1: After reset the run flag is 0, the FIFO reads empty with count 0 and not full, the overflow flag is 0, the result reads 0 and irq_o is low.
- R2: With the order bit at 0, each word enters the CRC register starting at bit (width-1) and ending at bit 0. Per bit: feedback = crc[len] XOR data bit, then crc = ((crc<<1) AND mask) XOR (feedback ? taps AND mask : 0). The mask covers bits len..0.
- R3: With the order bit at 1, each word enters starting at bit 0. Only the input order changes: the result is the normal, non-reflected value.
- R4: The register length is len+1 bits, with len a 5-bit field (ctrl[12:8]). The taps are two 16-bit halves at addresses 1 (low) and 2 (high). Result bits above position len read as 0.
- R5: The word width is field ctrl[20:16] plus one, from 1 to 32. Only the low width bits of a pushed word are used, and odd widths are handled.
- R6: The FIFO holds 8 words. A push at address 3 while full is dropped and sets the sticky overflow flag (ctrl[26]). Writing ctrl with bit 3 set clears that flag.
- R7: No word leaves the FIFO while the run flag (ctrl[0]) is 0.
- R8: With the interrupt select bit (ctrl[2]) at 0, irq_o pulses for one cycle in the cycle after the FIFO count goes from 1 to 0.
- R9: With ctrl[2] at 1, irq_o pulses for one cycle in the first cycle in which the engine has cleared the run flag. A software write that clears the run flag gives no pulse.
- R10: The run flag clears by itself once the FIFO is empty and the last word is fully shifted. This happens ceil(width/2)+1 cycles after the FIFO-drain pulse.
- R11: A write to the result register (address 4) loads the value, so writing 0 clears it. If no write is made, the next run continues from the stored value.
- R12: A read of ctrl returns the written order bit, select bit, len field and width field, plus full (bit 24), empty (bit 25), overflow (bit 26) and the word count (bits 31:28).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address: 0 ctrl, 1 taps low, 2 taps high, 3 FIFO push, 4 result |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
A wrong bit order, tap mask or step count corrupts the result read at address 4. The error shows as soon as the run flag drops, so each vector compares the full checksum of two words against a bench model. A FIFO pointer or count error shows in the ctrl status bits within one cycle, or as a wrong checksum over eight preloaded words. Interrupt and completion timing errors show as a pulse count or a drain-to-done distance that differs from the expected cycle count.

// File: rtl/crc_pkg.sv
package crc_pkg;
  localparam int unsigned XLEN   = 32;
  localparam int unsigned LEN_W  = 5;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL    = 3'd0,
    REG_TAPS_LO = 3'd1,
    REG_TAPS_HI = 3'd2,
    REG_PUSH    = 3'd3,
    REG_RESULT  = 3'd4
  } reg_addr_e;

  // ctrl field positions
  localparam int unsigned C_RUN     = 0;
  localparam int unsigned C_ORDER   = 1;
  localparam int unsigned C_SEL     = 2;
  localparam int unsigned C_CLR_OVF = 3;
  localparam int unsigned C_LEN     = 8;
  localparam int unsigned C_WID     = 16;
  localparam int unsigned S_FULL    = 24;
  localparam int unsigned S_EMPTY   = 25;
  localparam int unsigned S_OVF     = 26;
  localparam int unsigned S_CNT     = 28;

  function automatic logic [XLEN-1:0] crc_mask(input logic [LEN_W-1:0] len);
    return (~({XLEN{1'b1}} << len) << 1) | XLEN'(1);
  endfunction

  function automatic logic [XLEN-1:0] crc_bit(input logic [XLEN-1:0] crc,
                                              input logic [XLEN-1:0] taps,
                                              input logic [XLEN-1:0] mask,
                                              input logic [LEN_W-1:0] len,
                                              input logic din);
    logic fb;
    logic [XLEN-1:0] r;
    fb = crc[len] ^ din;
    r  = (crc << 1) & mask;
    if (fb) r = r ^ (taps & mask);
    return r;
  endfunction
endpackage

// File: rtl/crc_fifo.sv
module crc_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({push_i, pop_i})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign rdata_o = mem_q[rd_ptr_q];
  assign count_o = cnt_q;
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
endmodule

// File: rtl/crc_shift_engine.sv
module crc_shift_engine
  import crc_pkg::*;
#(
  parameter int unsigned BPC = 2,
  localparam int unsigned CNT_W = $clog2(XLEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [XLEN-1:0]  word_i,
  input  logic [LEN_W-1:0] wid_m1_i,
  input  logic             lsb_first_i,
  input  logic             crc_wr_i,
  input  logic [XLEN-1:0]  crc_wdata_i,
  input  logic [XLEN-1:0]  taps_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [XLEN-1:0]  crc_o,
  output logic             idle_o
);
  logic [XLEN-1:0]  sh_q, crc_q, crc_nxt, mask;
  logic [CNT_W-1:0] left_q, take;
  logic             ord_q;
  logic [XLEN-1:0]  chain [BPC+1];

  assign mask     = crc_mask(len_i);
  assign chain[0] = crc_q;
  assign take     = (left_q >= CNT_W'(BPC)) ? CNT_W'(BPC) : left_q;

  for (genvar k = 0; k < BPC; k++) begin : g_step
    logic din;
    assign din        = ord_q ? sh_q[k] : sh_q[XLEN-1-k];
    assign chain[k+1] = crc_bit(chain[k], taps_i, mask, len_i, din);
  end

  always_comb begin
    crc_nxt = chain[0];
    for (int k = 1; k <= BPC; k++) begin
      if (take == CNT_W'(k)) crc_nxt = chain[k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      left_q <= '0;
      ord_q  <= 1'b0;
      crc_q  <= '0;
    end else begin
      if (load_i) begin
        // msb-first words are left-aligned so bit width-1 sits at the top
        sh_q   <= lsb_first_i ? word_i : word_i << (LEN_W'(XLEN - 1) - wid_m1_i);
        left_q <= CNT_W'(wid_m1_i) + CNT_W'(1);
        ord_q  <= lsb_first_i;
      end else if (left_q != '0) begin
        sh_q   <= ord_q ? (sh_q >> take) : (sh_q << take);
        left_q <= left_q - take;
      end
      if (crc_wr_i)            crc_q <= crc_wdata_i;
      else if (left_q != '0)   crc_q <= crc_nxt;
    end
  end

  assign crc_o  = crc_q;
  assign idle_o = (left_q == '0);
endmodule

// File: rtl/crc_prog_engine.sv
module crc_prog_engine
  import crc_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH   = 8,
  parameter int unsigned BITS_PER_CLK = 2,
  localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [XLEN-1:0]   wdata_i,
  output logic [XLEN-1:0]   rdata_o,
  output logic              irq_o
);
  logic             run_q, lsb_q, sel_q, ovf_q, irq_q;
  logic [LEN_W-1:0] len_q, wid_m1_q;
  logic [XLEN-1:0]  taps_q;

  logic ctrl_wr, push_wr, res_wr, push, pop, auto_clr, drain_evt;
  logic [XLEN-1:0]  fifo_rdata, crc_val;
  logic [CNT_W-1:0] fifo_cnt;
  logic fifo_full, fifo_empty, eng_idle;

  assign ctrl_wr = wr_i && (addr_i == REG_CTRL);
  assign push_wr = wr_i && (addr_i == REG_PUSH);
  assign res_wr  = wr_i && (addr_i == REG_RESULT);

  assign push      = push_wr && !fifo_full;
  assign pop       = run_q && eng_idle && !fifo_empty;
  assign auto_clr  = run_q && eng_idle && fifo_empty && !ctrl_wr;
  assign drain_evt = pop && !push && (fifo_cnt == CNT_W'(1));

  crc_fifo #(.WIDTH(XLEN), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .wdata_i (wdata_i),
    .pop_i   (pop),
    .rdata_o (fifo_rdata),
    .count_o (fifo_cnt),
    .full_o  (fifo_full),
    .empty_o (fifo_empty)
  );

  crc_shift_engine #(.BPC(BITS_PER_CLK)) u_engine (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (pop),
    .word_i      (fifo_rdata),
    .wid_m1_i    (wid_m1_q),
    .lsb_first_i (lsb_q),
    .crc_wr_i    (res_wr),
    .crc_wdata_i (wdata_i),
    .taps_i      (taps_q),
    .len_i       (len_q),
    .crc_o       (crc_val),
    .idle_o      (eng_idle)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      lsb_q    <= 1'b0;
      sel_q    <= 1'b0;
      len_q    <= '0;
      wid_m1_q <= '0;
      taps_q   <= '0;
      ovf_q    <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        run_q    <= wdata_i[C_RUN];
        lsb_q    <= wdata_i[C_ORDER];
        sel_q    <= wdata_i[C_SEL];
        len_q    <= wdata_i[C_LEN +: LEN_W];
        wid_m1_q <= wdata_i[C_WID +: LEN_W];
      end else if (auto_clr) begin
        run_q <= 1'b0;
      end
      if (wr_i && (addr_i == REG_TAPS_LO)) taps_q[15:0]  <= wdata_i[15:0];
      if (wr_i && (addr_i == REG_TAPS_HI)) taps_q[31:16] <= wdata_i[15:0];
      if (push_wr && fifo_full)                  ovf_q <= 1'b1;
      else if (ctrl_wr && wdata_i[C_CLR_OVF])    ovf_q <= 1'b0;
      irq_q <= sel_q ? auto_clr : drain_evt;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_CTRL: begin
        rdata_o[C_RUN]             = run_q;
        rdata_o[C_ORDER]           = lsb_q;
        rdata_o[C_SEL]             = sel_q;
        rdata_o[C_LEN +: LEN_W]    = len_q;
        rdata_o[C_WID +: LEN_W]    = wid_m1_q;
        rdata_o[S_FULL]            = fifo_full;
        rdata_o[S_EMPTY]           = fifo_empty;
        rdata_o[S_OVF]             = ovf_q;
        rdata_o[S_CNT +: CNT_W]    = fifo_cnt;
      end
      REG_TAPS_LO: rdata_o[15:0] = taps_q[15:0];
      REG_TAPS_HI: rdata_o[15:0] = taps_q[31:16];
      REG_RESULT:  rdata_o       = crc_val & crc_mask(len_q);
      default:     rdata_o       = '0;
    endcase
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/crc_prog_engine_chk.sv
module crc_prog_engine_chk #(
  parameter int unsigned FIFO_DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             run_q,
  input logic             sel_q,
  input logic [CNT_W-1:0] fifo_cnt,
  input logic             fifo_full,
  input logic             fifo_empty,
  input logic             push,
  input logic             pop,
  input logic             push_wr,
  input logic             ctrl_wr,
  input logic             irq_o
);
  assert_count_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt <= CNT_W'(FIFO_DEPTH));

  assert_full_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_wr && fifo_full && !pop) |=> (fifo_full && $stable(fifo_cnt)));

  assert_no_pop_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_q && !push) |=> $stable(fifo_cnt));

  assert_irq_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  assert_drain_irq_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !sel_q && !$past(ctrl_wr)) |-> fifo_empty);

  assert_done_irq_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && sel_q) |-> (!run_q && fifo_empty));
endmodule

bind crc_prog_engine crc_prog_engine_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .run_q      (run_q),
  .sel_q      (sel_q),
  .fifo_cnt   (fifo_cnt),
  .fifo_full  (fifo_full),
  .fifo_empty (fifo_empty),
  .push       (push),
  .pop        (pop),
  .push_wr    (push_wr),
  .ctrl_wr    (ctrl_wr),
  .irq_o      (irq_o)
);

// File: tb/tb_crc_prog_engine.sv
module tb_crc_prog_engine;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  int irq_seen = 0;

  crc_prog_engine dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(negedge clk) if (rst_n && irq) irq_seen++;

  typedef struct packed {
    logic [31:0] taps;
    logic [4:0]  len;
    logic [4:0]  wm1;
    logic        lsb;
    logic [31:0] word;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{32'h04C11DB7, 5'd31, 5'd31, 1'b0, 32'h12345678}, // R2 full width
    '{32'h00001021, 5'd15, 5'd7,  1'b0, 32'h000000A5}, // R2
    '{32'h00001021, 5'd15, 5'd7,  1'b1, 32'h000000A5}, // R3
    '{32'h00000007, 5'd7,  5'd6,  1'b0, 32'hFFFFFF5B}, // R5 odd width, upper bits ignored
    '{32'h00008005, 5'd15, 5'd12, 1'b1, 32'h00001ABC}, // R3 R5
    '{32'h00000015, 5'd4,  5'd0,  1'b0, 32'h00000001}  // R4 R5 short reg, 1-bit width
  };

  function automatic logic [31:0] mdl(input logic [31:0] crc, input logic [31:0] taps,
                                      input logic [4:0] len, input logic [31:0] word,
                                      input logic [4:0] wm1, input logic lsb);
    logic [31:0] m, c;
    logic fb, b;
    m = 32'h0;
    for (int i = 0; i <= int'(len); i++) m[i] = 1'b1;
    c = crc & m;
    for (int i = 0; i <= int'(wm1); i++) begin
      b  = lsb ? word[i] : word[int'(wm1) - i];
      fb = c[len] ^ b;
      c  = (c << 1) & m;
      if (fb) c = c ^ (taps & m);
    end
    return c;
  endfunction

  function automatic logic [31:0] ctl(input logic run, input logic lsb, input logic sel,
                                      input logic clr, input logic [4:0] len, input logic [4:0] wm1);
    logic [31:0] v;
    v = '0;
    v[0] = run; v[1] = lsb; v[2] = sel; v[3] = clr;
    v[12:8] = len; v[20:16] = wm1;
    return v;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; addr = 3'd0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
    addr = 3'd0;
  endtask

  task automatic cfg(input logic [31:0] taps, input logic [4:0] len, input logic [4:0] wm1,
                     input logic lsb, input logic sel);
    wr_reg(3'd1, {16'h0, taps[15:0]});
    wr_reg(3'd2, {16'h0, taps[31:16]});
    wr_reg(3'd0, ctl(1'b0, lsb, sel, 1'b0, len, wm1));
  endtask

  task automatic wait_idle();
    logic [31:0] r;
    for (int i = 0; i < 2000; i++) begin
      rd_reg(3'd0, r);
      if (!r[0]) return;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    bad++; total++;
    $display("FAIL watchdog R10 run flag never cleared");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r, e, r1;
    int k, p0;

    repeat (3) @(negedge clk);
    // R1 reset state
    #1;
    chk(irq == 1'b0, "R1 irq", {31'h0, irq}, 32'h0);
    rd_reg(3'd0, r);
    chk(r[0] == 1'b0 && r[24] == 1'b0 && r[25] == 1'b1 && r[26] == 1'b0 && r[31:28] == 4'd0,
        "R1 ctrl", r, 32'h02000000);
    rd_reg(3'd4, r);
    chk(r == 32'h0, "R1 result", r, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 field readback
    cfg(32'h0000ABCD, 5'd13, 5'd21, 1'b1, 1'b1);
    rd_reg(3'd0, r);
    chk(r[20:0] == ctl(1'b0, 1'b1, 1'b1, 1'b0, 5'd13, 5'd21), "R12 ctrl fields", r[20:0],
        ctl(1'b0, 1'b1, 1'b1, 1'b0, 5'd13, 5'd21));
    rd_reg(3'd1, r);
    chk(r == 32'h0000ABCD, "R12 taps low", r, 32'h0000ABCD);

    // vector table: R2 R3 R4 R5
    foreach (VECS[i]) begin
      cfg(VECS[i].taps, VECS[i].len, VECS[i].wm1, VECS[i].lsb, 1'b0);
      wr_reg(3'd4, 32'h0);
      wr_reg(3'd3, VECS[i].word);
      wr_reg(3'd3, ~VECS[i].word);
      wr_reg(3'd0, ctl(1'b1, VECS[i].lsb, 1'b0, 1'b0, VECS[i].len, VECS[i].wm1));
      wait_idle();
      rd_reg(3'd4, r);
      e = mdl(mdl(32'h0, VECS[i].taps, VECS[i].len, VECS[i].word, VECS[i].wm1, VECS[i].lsb),
              VECS[i].taps, VECS[i].len, ~VECS[i].word, VECS[i].wm1, VECS[i].lsb);
      chk(r == e, VECS[i].lsb ? "R3 R5 lsb-first vector" : "R2 R5 msb-first vector", r, e);
    end

    // R4 upper result bits read zero
    cfg(32'h00000007, 5'd7, 5'd7, 1'b0, 1'b0);
    wr_reg(3'd4, 32'hFFFFFFFF);
    rd_reg(3'd4, r);
    chk(r == 32'h000000FF, "R4 result mask", r, 32'h000000FF);

    // R11 clear by writing zero, then resume
    wr_reg(3'd4, 32'h0);
    rd_reg(3'd4, r);
    chk(r == 32'h0, "R11 clear", r, 32'h0);
    cfg(32'h00001021, 5'd15, 5'd15, 1'b0, 1'b0);
    wr_reg(3'd4, 32'h0);
    wr_reg(3'd3, 32'h0000BEEF);
    wr_reg(3'd0, ctl(1'b1, 1'b0, 1'b0, 1'b0, 5'd15, 5'd15));
    wait_idle();
    rd_reg(3'd4, r1);
    wr_reg(3'd3, 32'h00001234);
    wr_reg(3'd0, ctl(1'b1, 1'b0, 1'b0, 1'b0, 5'd15, 5'd15));
    wait_idle();
    rd_reg(3'd4, r);
    e = mdl(mdl(32'h0, 32'h1021, 5'd15, 32'hBEEF, 5'd15, 1'b0), 32'h1021, 5'd15, 32'h1234, 5'd15, 1'b0);
    chk(r == e, "R11 resume", r, e);

    // R6 R7 overflow and hold while not running
    cfg(32'h04C11DB7, 5'd31, 5'd31, 1'b0, 1'b0);
    wr_reg(3'd4, 32'h0);
    for (int i = 0; i < 9; i++) wr_reg(3'd3, 32'h01010101 * (i + 1));
    rd_reg(3'd0, r);
    chk(r[24] == 1'b1 && r[26] == 1'b1 && r[31:28] == 4'd8, "R6 full and overflow", r, 32'h85000000);
    repeat (10) @(negedge clk);
    rd_reg(3'd0, r);
    chk(r[31:28] == 4'd8, "R7 no pop while idle", {28'h0, r[31:28]}, 32'd8);
    wr_reg(3'd0, ctl(1'b1, 1'b0, 1'b0, 1'b1, 5'd31, 5'd31));
    wait_idle();
    rd_reg(3'd4, r);
    e = 32'h0;
    for (int i = 0; i < 8; i++) e = mdl(e, 32'h04C11DB7, 5'd31, 32'h01010101 * (i + 1), 5'd31, 1'b0);
    chk(r == e, "R6 ninth word dropped", r, e);
    rd_reg(3'd0, r);
    chk(r[26] == 1'b0 && r[25] == 1'b1, "R6 overflow cleared", r, 32'h02000000);

    // R8 R10 drain pulse and completion distance, width 9 -> 6 cycles
    cfg(32'h00000007, 5'd7, 5'd8, 1'b0, 1'b0);
    wr_reg(3'd3, 32'h1A5);
    p0 = irq_seen;
    wr_reg(3'd0, ctl(1'b1, 1'b0, 1'b0, 1'b0, 5'd7, 5'd8));
    k = -1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk); #1;
      if (k < 0 && irq) begin
        k = 0;
        chk(rdata[31:28] == 4'd0, "R8 pulse when count hits zero", {28'h0, rdata[31:28]}, 32'h0);
      end else if (k >= 0) begin
        k++;
        if (!rdata[0]) break;
      end
    end
    chk(k == 6, "R10 drain to done cycles", k, 32'd6);
    chk(irq_seen - p0 == 1, "R8 single drain pulse", irq_seen - p0, 32'd1);

    // R9 done pulse coincides with cleared run flag
    cfg(32'h00001021, 5'd15, 5'd7, 1'b0, 1'b1);
    wr_reg(3'd3, 32'h5A);
    p0 = irq_seen;
    wr_reg(3'd0, ctl(1'b1, 1'b0, 1'b1, 1'b0, 5'd15, 5'd7));
    k = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk); #1;
      if (irq) begin
        k = 1;
        chk(rdata[0] == 1'b0, "R9 pulse with run cleared", {31'h0, rdata[0]}, 32'h0);
      end
    end
    chk(k == 1 && irq_seen - p0 == 1, "R9 one done pulse", irq_seen - p0, 32'd1);

    // R9 software clear gives no pulse
    wr_reg(3'd3, 32'h11);
    wr_reg(3'd3, 32'h22);
    p0 = irq_seen;
    wr_reg(3'd0, ctl(1'b1, 1'b0, 1'b1, 1'b0, 5'd15, 5'd7));
    wr_reg(3'd0, ctl(1'b0, 1'b0, 1'b1, 1'b0, 5'd15, 5'd7));
    repeat (40) @(negedge clk);
    chk(irq_seen == p0, "R9 no pulse on software clear", irq_seen - p0, 32'd0);
    rd_reg(3'd0, r);
    chk(r[0] == 1'b0 && r[31:28] == 4'd1, "R7 remaining word held", r, 32'h10000000);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule